// File: doc/BRIEF.md
# Two-Bit Accumulating Operation Sequencer

This block applies a chain of small arithmetic and logic operations to a 2-bit operand, one operation per clock step. One operand (X) and a 2-bit operation select arrive from outside at every step. The other operand (Y) sits in a register. At each rising edge that register either takes a fresh external value or takes the result of the step that just finished. A series such as "load a value, OR in a second value, OR in a third, then AND with a mask" therefore runs as a sequence of steps, with the result of each step feeding the next.

Four operations are available: invert Y, bitwise AND of X and Y, bitwise OR of X and Y, and the unsigned sum of X and Y with a carry out. The result is computed combinationally from the registered Y, the current X and the current select. It is therefore visible during the step, before the edge that may store it. Only the data bits of the result go back into the register. The carry is reported on its own output and is never stored.

Top module: `accum_op_seq`

## Requirements
- R1: A synchronous active-high reset clears the Y register to 00, whatever the load input does during that edge.
- R2: With select 11 the result is the bitwise inverse of the registered Y, and X has no effect on it.
- R3: With select 10 the result is the bitwise AND of X and the registered Y.
- R4: With select 01 the result is the bitwise OR of X and the registered Y.
- R5: With select 00 the 3-bit value {carry_out, res} is the unsigned sum of X and the registered Y.
- R6: carry_out is 0 whenever the select is not 00.
- R7: When load is 1 at a rising edge, the Y register takes y_in.
- R8: When load is 0 at a rising edge, the Y register takes the current res (res[1] into Y[1], res[0] into Y[0]), and the carry of an add step is dropped.
- R9: While load is 0, y_in has no effect on the next Y value.
- R10: res and carry_out follow changes of X and of the select within a cycle, with no clock edge needed.
- R11: The select may change on every step, and a multi-step chain matches a step-by-step model of R2 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the Y register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Operation select: 00 add, 01 OR, 10 AND, 11 invert Y |
| x_in | input | 2 | External X operand for the current step |
| y_in | input | 2 | External value stored into Y when load is 1 |
| load | input | 1 | 1 stores y_in into Y, 0 feeds res back into Y |
| res | output | 2 | Data result of the current step |
| carry_out | output | 1 | Carry of an add step; 0 for the other operations |

## Verification
res and carry_out depend on the current select and X within the same cycle, so they are due as soon as the inputs settle. A change to Y only shows up after the next rising edge. The bench drives every input on the falling edge and samples the outputs 2 ns later. Its model of Y advances once on each rising edge, so every comparison falls in the half cycle after that edge, away from it. The combinational check in R10 changes X a second time in the same low phase and samples again before the rising edge.

// File: rtl/accum_op_seq_pkg.sv
package accum_op_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_OR  = 2'b01,
    OP_AND = 2'b10,
    OP_INV = 2'b11
  } op_sel_e;

endpackage

// File: rtl/accum_op_unit.sv
module accum_op_unit
  import accum_op_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  op_sel_e        op,
  input  logic [W-1:0]   a_opnd,
  input  logic [W-1:0]   b_opnd,
  output logic [W-1:0]   result,
  output logic           carry
);

  localparam int SW = W + 1;

  logic [W-1:0]  and_v;
  logic [W-1:0]  or_v;
  logic [W-1:0]  inv_v;
  logic [SW-1:0] sum_v;

  // per-bit logic lanes
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_lane
      assign and_v[i] = a_opnd[i] & b_opnd[i];
      assign or_v[i]  = a_opnd[i] | b_opnd[i];
      assign inv_v[i] = ~b_opnd[i];
    end
  endgenerate

  assign sum_v = {1'b0, a_opnd} + {1'b0, b_opnd};

  always_comb begin
    carry  = 1'b0;
    result = '0;
    unique case (op)
      OP_ADD: begin
        result = sum_v[W-1:0];
        carry  = sum_v[W];
      end
      OP_OR:   result = or_v;
      OP_AND:  result = and_v;
      OP_INV:  result = inv_v;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/accum_operand_reg.sv
module accum_operand_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] fb_val,
  output logic [W-1:0] q
);

  logic [W-1:0] d;

  assign d = load ? ext_val : fb_val;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/accum_op_seq.sv
module accum_op_seq
  import accum_op_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         load,
  output logic [W-1:0] res,
  output logic         carry_out
);

  logic [W-1:0] y_q;
  op_sel_e      op;

  assign op = op_sel_e'(sel);

  accum_operand_reg #(.W(W)) u_yreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ext_val (y_in),
    .fb_val  (res),
    .q       (y_q)
  );

  accum_op_unit #(.W(W)) u_alu (
    .op     (op),
    .a_opnd (x_in),
    .b_opnd (y_q),
    .result (res),
    .carry  (carry_out)
  );

endmodule

// File: rtl/accum_op_seq_chk.sv
module accum_op_seq_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   sel,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic         load,
  input logic [W-1:0] y_q,
  input logic [W-1:0] res,
  input logic         carry_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (y_q == '0));

  // R7
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (y_q == $past(y_in)));

  // R8
  feedback_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (y_q == $past(res)));

  // R2
  invert_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |-> (res == ~y_q));

  // R5
  add_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> ({carry_out, res} == ({1'b0, x_in} + {1'b0, y_q})));

  // R6
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != 2'b00) |-> (carry_out == 1'b0));

endmodule

bind accum_op_seq accum_op_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .x_in      (x_in),
  .y_in      (y_in),
  .load      (load),
  .y_q       (y_q),
  .res       (res),
  .carry_out (carry_out)
);

// File: tb/accum_op_seq_tb.sv
module accum_op_seq_tb;

  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   sel;
  logic [W-1:0] x_in;
  logic [W-1:0] y_in;
  logic         load;
  logic [W-1:0] res;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] m_y;
  bit done = 1'b0;

  always #10 clk = ~clk;

  accum_op_seq #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .x_in(x_in),
    .y_in(y_in), .load(load), .res(res), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(input logic [1:0] s,
                                       input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    case (s)
      2'b00:   return {1'b0, a} + {1'b0, b};
      2'b01:   return {1'b0, a | b};
      2'b10:   return {1'b0, a & b};
      default: return {1'b0, ~b};
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive one step on the falling edge, check its outputs, then cross the rising edge
  task automatic step(input string req, input logic [1:0] s, input logic [W-1:0] a,
                      input logic ld, input logic [W-1:0] yv);
    logic [W:0] e;
    @(negedge clk);
    sel = s; x_in = a; load = ld; y_in = yv;
    #2;
    e = model(s, a, m_y);
    check(req, {carry_out, res}, e);
    @(posedge clk);
    m_y = ld ? yv : e[W-1:0];
  endtask

  task automatic t_reset();
    step("R7", 2'b01, 2'b00, 1'b1, 2'b11);
    @(negedge clk);
    rst = 1'b1; load = 1'b1; y_in = 2'b10;
    @(posedge clk);
    m_y = '0;
    @(negedge clk);
    rst = 1'b0; sel = 2'b01; x_in = 2'b00; load = 1'b1; y_in = 2'b00;
    #2;
    // R1: Y cleared, seen through OR with zero X
    check("R1", {carry_out, res}, 3'b000);
    @(posedge clk);
  endtask

  task automatic t_exhaustive();
    for (int s = 0; s < 4; s++) begin
      for (int y = 0; y < 4; y++) begin
        step("R7", 2'b01, 2'b00, 1'b1, 2'(y));
        for (int x = 0; x < 4; x++) begin
          // R2 R3 R4 R5 R6 for every operand pair, Y reloaded each step
          case (s)
            0: step("R5", 2'(s), 2'(x), 1'b1, 2'(y));
            1: step("R4", 2'(s), 2'(x), 1'b1, 2'(y));
            2: step("R3", 2'(s), 2'(x), 1'b1, 2'(y));
            default: step("R2", 2'(s), 2'(x), 1'b1, 2'(y));
          endcase
        end
      end
    end
  endtask

  task automatic t_no_carry();
    step("R7", 2'b01, 2'b00, 1'b1, 2'b11);
    step("R6", 2'b01, 2'b11, 1'b1, 2'b11);
    step("R6", 2'b10, 2'b11, 1'b1, 2'b11);
    step("R6", 2'b11, 2'b11, 1'b1, 2'b11);
  endtask

  task automatic t_carry_drop();
    step("R7", 2'b01, 2'b00, 1'b1, 2'b11);
    // 11 + 11 = 110: carry shown, only 10 fed back
    step("R8", 2'b00, 2'b11, 1'b0, 2'b00);
    step("R8", 2'b01, 2'b00, 1'b1, 2'b00);
    check("R8", {1'b0, m_y}, 3'b000);
  endtask

  task automatic t_ignore_ext();
    step("R7", 2'b01, 2'b00, 1'b1, 2'b01);
    step("R9", 2'b01, 2'b00, 1'b0, 2'b11);
    // Y must still be 01, not the ignored 11
    @(negedge clk);
    sel = 2'b01; x_in = 2'b00; load = 1'b1; y_in = 2'b01;
    #2;
    check("R9", {carry_out, res}, 3'b001);
    @(posedge clk);
    m_y = 2'b01;
  endtask

  task automatic t_comb();
    step("R7", 2'b01, 2'b00, 1'b1, 2'b01);
    @(negedge clk);
    sel = 2'b01; x_in = 2'b00; load = 1'b1; y_in = 2'b01;
    #2;
    check("R10", {carry_out, res}, 3'b001);
    x_in = 2'b10;
    #2;
    check("R10", {carry_out, res}, 3'b011);
    sel = 2'b00; x_in = 2'b11;
    #2;
    check("R10", {carry_out, res}, 3'b100);
    @(posedge clk);
    m_y = 2'b01;
  endtask

  task automatic t_chain();
    // load 00, OR 01, OR 10, AND 10, invert, add 01, AND 11
    step("R11", 2'b01, 2'b00, 1'b1, 2'b00);
    step("R11", 2'b01, 2'b01, 1'b0, 2'b11);
    step("R11", 2'b01, 2'b10, 1'b0, 2'b00);
    step("R11", 2'b10, 2'b10, 1'b0, 2'b01);
    step("R11", 2'b11, 2'b00, 1'b0, 2'b10);
    step("R11", 2'b00, 2'b01, 1'b0, 2'b11);
    step("R11", 2'b10, 2'b11, 1'b0, 2'b00);
    step("R11", 2'b01, 2'b00, 1'b1, 2'b00);
    // 00|01|10 = 11, &10 = 10, ~ = 01, +01 = 10, &11 = 10
    check("R11", {1'b0, m_y}, 3'b000);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel = 2'b00; x_in = '0; y_in = '0; load = 1'b0; m_y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exhaustive();
    t_no_carry();
    t_carry_drop();
    t_ignore_ext();
    t_comb();
    t_chain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule